// File: doc/BRIEF.md
# Per-slot INTx to PIRQ mapper

This block decides which of eight shared interrupt lines (PIRQ 0 to 7) carries each legacy interrupt pin (INTA to INTD) of every PCI device slot. Seven slots, numbered 25 to 31, take their mapping from a small chipset register window. Slot 30 is hard-wired. Every other slot follows a fixed swizzle formula. Interrupt routing logic further downstream asks the lookup port which line a given slot and pin use, and the answer comes back combinationally in the same cycle.

A host reads and writes the 32-byte window through one byte-addressed access port. An access is 1, 2 or 4 bytes wide, and the lanes are little-endian. The address is folded into the window. An access that would run past the top byte is cut short there; it never wraps. Each write produces a one-cycle notice so that downstream logic can refresh any mapping it has cached. Besides the slot registers, the window holds a 32-bit general control word with a non-zero default. The remaining bytes are plain storage that resets to zero.

Top module: `irqmap_top`

## Requirements
- R1: After reset, every window byte reads zero except in two places. Each programmable slot register other than slot 30 reads 0x3210. The control word at byte offset 16 reads 0x00000001.
- R2: Slot s, for s from 25 to 31, owns a 16-bit little-endian register at byte offset 2*(s-25). Pin p (0=INTA to 3=INTD) has a 4-bit field at bits 4p+3:4p. The lookup returns the low 3 bits of that field, and bit 3 has no effect.
- R3: The slot 30 register (bytes 10 and 11) always reads zero and ignores writes. A lookup of slot 30 pin p returns 4+p.
- R4: For any slot s below 25, a lookup of pin p returns ((s+p) mod 4)+4, whatever the window holds.
- R5: Only the low 5 address bits select a byte. Higher address bits are ignored.
- R6: Size code 0, 1 and 2 access 1, 2 and 4 bytes, and code 3 acts as 4 bytes. Byte offset+k travels on data bits 8k+7:8k. Read lanes beyond the access length return zero.
- R7: An access starting at offset o is shortened to 32-o bytes when o+length exceeds 32. The bytes past the top are neither written nor wrapped to offset 0, and their read lanes return zero.
- R8: route_chg is high for exactly the cycle after each accepted write, including writes that all land on locked bytes. It is never high otherwise.
- R9: A write takes effect at the next clock edge. A read or lookup made in the same cycle as a write sees the contents from before that write.
- R10: Bytes outside the slot registers, control word included, are ordinary read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte address, folded into the window |
| acc_size | input | 2 | Access size code |
| acc_wdata | input | 32 | Write data, little-endian lanes |
| acc_rdata | output | 32 | Read data for acc_addr/acc_size, combinational |
| lk_slot | input | 5 | Device slot number to look up |
| lk_pin | input | 2 | Interrupt pin to look up (0=INTA) |
| lk_pirq | output | 3 | PIRQ index for that slot and pin |
| route_chg | output | 1 | One-cycle pulse after each write |

## Verification
A register write and a lookup or read of the same register can fall in the same clock cycle. The bench provokes this by holding a halfword write to the slot 25 register while the lookup port points at slot 25 and the access port presents that register for reading. Just before the clock edge, the bench expects both the lookup and the read data to still show the old value. After the edge, it expects both to show the new value, and it expects route_chg to be high for that one cycle only.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

  localparam int SLOT_W          = 5;
  localparam int PIN_W           = 2;
  localparam int PIRQ_W          = 3;
  localparam int DATA_BYTES      = 4;
  localparam int FIRST_PROG_SLOT = 25;
  localparam int LAST_PROG_SLOT  = 31;
  localparam int FIXED_SLOT      = 30;
  localparam int PROG_SLOTS      = LAST_PROG_SLOT - FIRST_PROG_SLOT + 1;
  localparam int SLOT_REG_BYTES  = 2;
  localparam int SLOT_AREA_BYTES = PROG_SLOTS * SLOT_REG_BYTES;
  localparam int FIXED_OFS       = (FIXED_SLOT - FIRST_PROG_SLOT) * SLOT_REG_BYTES;
  localparam int CTRL_OFS        = 16;
  localparam logic [15:0] SLOT_REG_DEFAULT = 16'h3210;
  localparam logic [31:0] CTRL_DEFAULT     = 32'h0000_0001;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  // Requested length in bytes before clipping; code 3 behaves as a word.
  function automatic int access_len(logic [1:0] code);
    case (code)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return 4;
    endcase
  endfunction

  // Bytes of the hard-wired slot register are never stored.
  function automatic logic byte_locked(int idx);
    return (idx == FIXED_OFS) || (idx == FIXED_OFS + 1);
  endfunction

  // Value a window byte takes on reset.
  function automatic logic [7:0] reset_byte(int idx);
    logic [31:0] ctrl;
    ctrl = CTRL_DEFAULT;
    if (idx < SLOT_AREA_BYTES) begin
      if (byte_locked(idx)) return 8'h00;
      return idx[0] ? SLOT_REG_DEFAULT[15:8] : SLOT_REG_DEFAULT[7:0];
    end
    if (idx >= CTRL_OFS && idx < CTRL_OFS + 4)
      return ctrl[8*(idx-CTRL_OFS) +: 8];
    return 8'h00;
  endfunction

endpackage

// File: rtl/irqmap_window.sv
module irqmap_window
  import irqmap_pkg::*;
#(
  parameter int WIN_BYTES = 32,
  localparam int OFS_W    = $clog2(WIN_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc_valid,
  input  logic                        acc_write,
  input  logic [OFS_W-1:0]            acc_ofs,
  input  logic [1:0]                  acc_size,
  input  logic [8*DATA_BYTES-1:0]     acc_wdata,
  output logic [8*DATA_BYTES-1:0]     acc_rdata,
  output logic [8*SLOT_AREA_BYTES-1:0] slot_flat,
  output logic                        route_chg
);

  logic [7:0] bytes_q [WIN_BYTES];
  logic [7:0] bytes_d [WIN_BYTES];
  logic       wr_en;
  logic       route_chg_q;
  int         eff_len;

  // Clip the requested length so it stops at the last window byte.
  always_comb begin
    int room;
    room    = WIN_BYTES - int'(acc_ofs);
    eff_len = access_len(acc_size);
    if (eff_len > room) eff_len = room;
  end

  assign wr_en = acc_valid & acc_write;

  // Next state of the byte array.
  always_comb begin
    for (int i = 0; i < WIN_BYTES; i++) begin
      int         rel;
      logic [1:0] lane;
      rel        = i - int'(acc_ofs);
      lane       = rel[1:0];
      bytes_d[i] = bytes_q[i];
      if (rel >= 0 && rel < eff_len && !byte_locked(i))
        bytes_d[i] = acc_wdata[8*lane +: 8];
    end
  end

  // Read lanes, zero beyond the clipped length.
  always_comb begin
    for (int k = 0; k < DATA_BYTES; k++) begin
      logic [OFS_W-1:0] idx;
      idx = acc_ofs + OFS_W'(k);
      acc_rdata[8*k +: 8] = (k < eff_len) ? bytes_q[idx] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN_BYTES; i++) bytes_q[i] <= reset_byte(i);
      route_chg_q <= 1'b0;
    end else begin
      if (wr_en) bytes_q <= bytes_d;
      route_chg_q <= wr_en;
    end
  end

  for (genvar b = 0; b < SLOT_AREA_BYTES; b++) begin : g_slot_bytes
    assign slot_flat[8*b +: 8] = bytes_q[b];
  end

  assign route_chg = route_chg_q;

endmodule

// File: rtl/irqmap_lookup.sv
module irqmap_lookup
  import irqmap_pkg::*;
(
  input  logic [8*SLOT_AREA_BYTES-1:0] slot_flat,
  input  logic [SLOT_W-1:0]            lk_slot,
  input  logic [PIN_W-1:0]             lk_pin,
  output logic [PIRQ_W-1:0]            lk_pirq
);

  logic fixed_reg_unused;
  assign fixed_reg_unused = ^slot_flat[8*FIXED_OFS +: 16];

  always_comb begin
    int         slot_i;
    int         base;
    logic [1:0] swz;
    slot_i = int'(lk_slot);
    swz    = lk_slot[1:0] + lk_pin;
    base   = 0;
    if (slot_i == FIXED_SLOT) begin
      lk_pirq = {1'b1, lk_pin};
    end else if (slot_i >= FIRST_PROG_SLOT) begin
      base    = 16 * (slot_i - FIRST_PROG_SLOT) + 4 * int'(lk_pin);
      lk_pirq = slot_flat[base +: PIRQ_W];
    end else begin
      lk_pirq = {1'b1, swz};
    end
  end

endmodule

// File: rtl/irqmap_top.sv
module irqmap_top
  import irqmap_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WIN_BYTES = 32,
  localparam int OFS_W    = $clog2(WIN_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic                    acc_write,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic [1:0]              acc_size,
  input  logic [8*DATA_BYTES-1:0] acc_wdata,
  output logic [8*DATA_BYTES-1:0] acc_rdata,
  input  logic [SLOT_W-1:0]       lk_slot,
  input  logic [PIN_W-1:0]        lk_pin,
  output logic [PIRQ_W-1:0]       lk_pirq,
  output logic                    route_chg
);

  logic [1:0]                   rst_pipe_q;
  logic                         rst_sync_n;
  logic [8*SLOT_AREA_BYTES-1:0] slot_flat;
  logic                         addr_hi_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign addr_hi_unused = ^acc_addr[ADDR_W-1:OFS_W];

  irqmap_window #(.WIN_BYTES(WIN_BYTES)) u_window (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_ofs   (acc_addr[OFS_W-1:0]),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .slot_flat (slot_flat),
    .route_chg (route_chg)
  );

  irqmap_lookup u_lookup (
    .slot_flat (slot_flat),
    .lk_slot   (lk_slot),
    .lk_pin    (lk_pin),
    .lk_pirq   (lk_pirq)
  );

endmodule

// File: rtl/irqmap_chk.sv
module irqmap_chk
  import irqmap_pkg::*;
(
  input logic                    clk,
  input logic                    rst_ok_n,
  input logic                    acc_valid,
  input logic                    acc_write,
  input logic [4:0]              acc_ofs,
  input logic [1:0]              acc_size,
  input logic [8*DATA_BYTES-1:0] acc_rdata,
  input logic [SLOT_W-1:0]       lk_slot,
  input logic [PIN_W-1:0]        lk_pin,
  input logic [PIRQ_W-1:0]       lk_pirq,
  input logic                    route_chg
);

  a_r8_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (acc_valid && acc_write) |=> route_chg);

  a_r8_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !(acc_valid && acc_write) |=> !route_chg);

  a_r3_fixed_slot_lookup: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (int'(lk_slot) == FIXED_SLOT) |-> (int'(lk_pirq) == int'(lk_pin) + 4));

  a_r4_swizzle_lookup: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (int'(lk_slot) < FIRST_PROG_SLOT) |->
      (int'(lk_pirq) == ((int'(lk_slot) + int'(lk_pin)) % 4) + 4));

  a_r3_fixed_reg_reads_zero: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (int'(acc_ofs) == FIXED_OFS && acc_size == SZ_HALF) |-> (acc_rdata == '0));

  a_r7_top_byte_clipped: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (acc_ofs == 5'd31) |-> (acc_rdata[31:8] == 24'h0));

  a_r9_lookup_holds: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!$past(acc_valid && acc_write) && $stable(lk_slot) && $stable(lk_pin))
      |-> $stable(lk_pirq));

endmodule

bind irqmap_top irqmap_chk u_chk (
  .clk       (clk),
  .rst_ok_n  (rst_sync_n),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_ofs   (acc_addr[4:0]),
  .acc_size  (acc_size),
  .acc_rdata (acc_rdata),
  .lk_slot   (lk_slot),
  .lk_pin    (lk_pin),
  .lk_pirq   (lk_pirq),
  .route_chg (route_chg)
);

// File: tb/tb_irqmap_top.sv
`timescale 1ns/1ps
module tb_irqmap_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic [7:0]  acc_addr;
  logic [1:0]  acc_size;
  logic [31:0] acc_wdata, acc_rdata;
  logic [4:0]  lk_slot;
  logic [1:0]  lk_pin;
  logic [2:0]  lk_pirq;
  logic        route_chg;

  int checks = 0;
  int failures = 0;
  logic [7:0] mdl [32];

  always #2.5 clk = ~clk;

  irqmap_top dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .lk_slot(lk_slot), .lk_pin(lk_pin),
    .lk_pirq(lk_pirq), .route_chg(route_chg)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int clip_len(int ofs, logic [1:0] sz);
    int n;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    if (ofs + n > 32) n = 32 - ofs;
    return n;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] addr, logic [1:0] sz);
    logic [31:0] r;
    int ofs;
    ofs = int'(addr) % 32;
    r = 32'h0;
    for (int k = 0; k < clip_len(ofs, sz); k++) r[8*k +: 8] = mdl[ofs+k];
    return r;
  endfunction

  function automatic logic [2:0] exp_pirq(int s, int p);
    logic [7:0] b;
    logic [3:0] nib;
    if (s == 30) return 3'(4 + p);
    if (s >= 25) begin
      b   = mdl[2*(s-25) + p/2];
      nib = (p % 2 == 1) ? b[7:4] : b[3:0];
      return nib[2:0];
    end
    return 3'(((s + p) % 4) + 4);
  endfunction

  task automatic do_write(logic [7:0] addr, logic [1:0] sz, logic [31:0] data);
    int ofs;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1;
    acc_addr = addr; acc_size = sz; acc_wdata = data;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    check("R8 pulse after write", {31'h0, route_chg}, 32'h1);
    ofs = int'(addr) % 32;
    for (int k = 0; k < clip_len(ofs, sz); k++)
      if (ofs + k != 10 && ofs + k != 11) mdl[ofs+k] = data[8*k +: 8];
  endtask

  task automatic check_read(string req, logic [7:0] addr, logic [1:0] sz);
    @(negedge clk);
    acc_addr = addr; acc_size = sz;
    #1 check(req, acc_rdata, exp_read(addr, sz));
  endtask

  task automatic sweep_lookup(string req);
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) begin
        lk_slot = 5'(s); lk_pin = 2'(p);
        #0.1 check(req, {29'h0, lk_pirq}, {29'h0, exp_pirq(s, p)});
      end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
    acc_addr = '0; acc_size = '0; acc_wdata = '0; lk_slot = '0; lk_pin = '0;
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    for (int s = 25; s < 32; s++)
      if (s != 30) begin mdl[2*(s-25)] = 8'h10; mdl[2*(s-25)+1] = 8'h32; end
    mdl[16] = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset contents, byte by byte and as halfword/word reads.
    for (int i = 0; i < 32; i++) check_read("R1 reset byte", 8'(i), 2'd0);
    check_read("R1 control word default", 8'd16, 2'd2);
    check_read("R1 slot 25 default", 8'd0, 2'd1);
    check("R8 idle after reset", {31'h0, route_chg}, 32'h0);
    sweep_lookup("R2 R3 R4 lookup after reset");

    // Program every slot register, bit 3 of each field set on odd pins.
    for (int s = 25; s < 32; s++) begin
      logic [15:0] v;
      for (int p = 0; p < 4; p++)
        v[4*p +: 4] = 4'(((s*3 + p*5) % 8) + ((p % 2) * 8));
      do_write(8'(2*(s-25)), 2'd1, {16'h0, v});
    end
    check_read("R3 slot 30 register reads zero", 8'd10, 2'd1);
    check_read("R2 slot 31 register", 8'd12, 2'd1);
    sweep_lookup("R2 R3 R4 lookup after programming");

    // Pulse lasts one cycle; reads raise none.
    @(negedge clk);
    check("R8 pulse is one cycle", {31'h0, route_chg}, 32'h0);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 8'd0; acc_size = 2'd2;
    @(negedge clk);
    acc_valid = 1'b0;
    check("R8 no pulse on read", {31'h0, route_chg}, 32'h0);

    // Free storage and control word.
    do_write(8'd20, 2'd2, 32'hA5C3_0F96);
    check_read("R10 free word", 8'd20, 2'd2);
    do_write(8'd16, 2'd0, 32'h0000_007E);
    check_read("R10 control word byte write", 8'd16, 2'd2);
    do_write(8'd24, 2'd3, 32'h1357_9BDF);
    check_read("R6 size code 3 is a word", 8'd24, 2'd2);
    check_read("R6 unaligned halfword lanes", 8'd21, 2'd1);

    // Clipping at the window top.
    do_write(8'd30, 2'd2, 32'hDEAD_BEEF);
    check_read("R7 top bytes written", 8'd30, 2'd1);
    check_read("R7 no wrap into byte 0", 8'd0, 2'd2);
    check_read("R7 read lanes past top zero", 8'd29, 2'd2);
    do_write(8'd31, 2'd1, 32'h0000_4C3B);
    check_read("R7 single top byte", 8'd31, 2'd2);

    // Address folding.
    do_write(8'hE8, 2'd1, 32'h0000_7654);
    check_read("R5 folded write lands at byte 8", 8'd8, 2'd1);
    check_read("R5 folded read", 8'hA8, 2'd1);
    do_write(8'h4A, 2'd1, 32'h0000_FFFF);
    check_read("R3 folded write to slot 30 ignored", 8'd10, 2'd1);
    sweep_lookup("R2 R3 R4 R5 lookup after folding");

    // Write and lookup/read of the same register in one cycle.
    @(negedge clk);
    lk_slot = 5'd25; lk_pin = 2'd1;
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 8'd0; acc_size = 2'd1;
    acc_wdata = 32'h0000_0567;
    #1;
    check("R9 lookup sees old value", {29'h0, lk_pirq}, {29'h0, exp_pirq(25, 1)});
    check("R9 read sees old value", acc_rdata, exp_read(8'd0, 2'd1));
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    mdl[0] = 8'h67; mdl[1] = 8'h05;
    check("R8 pulse after same-cycle write", {31'h0, route_chg}, 32'h1);
    check("R9 lookup sees new value", {29'h0, lk_pirq}, 32'h6);
    check("R9 read sees new value", acc_rdata, 32'h0000_0567);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule